// File: doc/BRIEF.md
# Paged Serial Register-Access Front End

This block sits behind the word-level receiver of a 16-bit serial link on the slave side. Words from the host arrive one at a time. They alternate between a command word and a data word. The command word says whether the host wants to read or write. It also names a register page and a register offset within that page. The following data word is then written into the selected register. A read is instead served when the link asks the slave for a word to send back.

The front end owns the framing state: it knows whether the next word is a command or data. It also holds the current page and offset, and it steers every access to one of three register banks. Each bank has its own write strobe, its own read strobe and its own read-data lane, and all banks share one address bus and one write-data bus. Each read moves the offset on by one, so a single command can be followed by a run of sequential reads.

Protocol misuse raises sticky error bits, and those bits are cleared only by reset. Every access that reaches a bank produces a one-cycle update pulse for the downstream conversion and interrupt logic.

Top module: `pserFrontEnd`

## Requirements
- R1: After reset, all error bits, `rdValid` and `updStrobe` are 0, no bank strobe is active, and the next word is taken as a command.
- R2: In a command word, bit 15 is the read flag, bits 14:11 are the page and bits 10:5 are the offset. Bits 4:0 have no effect.
- R3: A data word that follows a command without the read flag drives the write strobe of the selected bank in the same cycle, with `bankAddr` equal to the offset and `bankWdata` equal to the word. The next word is then taken as a command.
- R4: Bank index equals page: page 0 selects `bankWe[0]`/`bankRe[0]` (data bank), page 1 selects index 1 (control bank) and page 2 selects index 2 (audio bank). At most one strobe is active at a time.
- R5: A `readReq` pulse returns the register at the current page and offset on `rdData`, with `rdValid` high exactly one cycle later. The offset then increments, wrapping from 63 to 0, and the next word is taken as a command.
- R6: A data word that follows a command with the read flag set is an overrun. It writes no register, sets `errOverrun`, and the next word is taken as a command.
- R7: A read requested when the last command had no read flag (including after reset) sets `errUnderrun`. The read is still served.
- R8: A page of 3 or more activates no bank strobe and sets `errBadPage`. A read from such a page returns 16'hFFFF.
- R9: Once set, each error bit stays set until reset.
- R10: `updStrobe` is high for exactly one cycle, in the cycle after each bank write or bank read, and is low otherwise.
- R11: If `wordValid` and `readReq` are high in the same cycle, the word is handled and the read request is dropped (no `rdValid`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordValid | input | 1 | A received word is present on `wordIn` |
| wordIn | input | 16 | Received word (command or data) |
| readReq | input | 1 | Link requests a word to transmit |
| rdValid | output | 1 | `rdData` holds a read result |
| rdData | output | 16 | Read result |
| bankWe | output | 3 | Per-bank write strobe |
| bankRe | output | 3 | Per-bank read strobe |
| bankAddr | output | 6 | Register offset within the bank |
| bankWdata | output | 16 | Write data to the banks |
| bankRdata | input | 48 | Read lanes; bank k on bits 16k+15:16k |
| errOverrun | output | 1 | Sticky overrun error |
| errUnderrun | output | 1 | Sticky underrun error |
| errBadPage | output | 1 | Sticky invalid-page error |
| updStrobe | output | 1 | One-cycle pulse after each bank access |

## Verification
Two kinds of result have different timing. Bank write strobes, address and write data are combinational, so they are due in the same cycle as the data word. The bench samples them one time unit after it drives that word, which is before the capturing edge. Read data, `rdValid`, the error bits and `updStrobe` are registered and appear after the edge that takes the request. The bench therefore samples them at the falling edge that follows. In a scoreboard, each read request pushes its expected value, and a monitor pops that value on every falling edge where `rdValid` is high. An empty queue at that point counts as an unexpected read.

// File: rtl/pserFePkg.sv
package pserFePkg;

  // Per-cycle decisions handed from control to datapath.
  typedef struct packed {
    logic loadCmd;     // capture command fields
    logic doWrite;     // legal write reaches a bank
    logic readGo;      // read request accepted
    logic doRead;      // accepted read hits a legal bank
    logic setOverrun;
    logic setUnderrun;
    logic setBadPage;
  } feStrobe_t;

endpackage

// File: rtl/pserFeCtrl.sv
module pserFeCtrl
  import pserFePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wordValid,
  input  logic      readReq,
  input  logic      readFlag,
  input  logic      pageOk,
  output feStrobe_t strb,
  output logic      expectData
);

  logic dataWord;
  logic readGo;

  assign dataWord = wordValid && expectData;
  assign readGo   = readReq && !wordValid;   // a word wins over a read

  always_comb begin
    strb             = '0;
    strb.loadCmd     = wordValid && !expectData;
    strb.doWrite     = dataWord && !readFlag && pageOk;
    strb.readGo      = readGo;
    strb.doRead      = readGo && pageOk;
    strb.setOverrun  = dataWord && readFlag;
    strb.setUnderrun = readGo && !readFlag;
    strb.setBadPage  = !pageOk && ((dataWord && !readFlag) || readGo);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                expectData <= 1'b0;
    else if (strb.loadCmd)    expectData <= 1'b1;
    else if (dataWord || readGo) expectData <= 1'b0;
  end

  a_r6_overrun_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    (expectData && wordValid && readFlag) |-> !strb.doWrite);

  a_r5_read_returns_to_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (readReq && !wordValid) |=> !expectData);

  a_r3_data_returns_to_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && expectData) |=> !expectData);

  a_r11_word_wins: assert property (@(posedge clk) disable iff (!rstN)
    (readReq && wordValid) |-> !strb.readGo);

endmodule

// File: rtl/pserFeDatapath.sv
module pserFeDatapath
  import pserFePkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int PAGE_W    = 4,
  parameter int OFF_W     = 6,
  parameter int NUM_BANKS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  feStrobe_t                   strb,
  input  logic [WORD_W-1:0]           wordIn,
  input  logic [NUM_BANKS*WORD_W-1:0] bankRdata,
  output logic                        readFlag,
  output logic                        pageOk,
  output logic [NUM_BANKS-1:0]        bankWe,
  output logic [NUM_BANKS-1:0]        bankRe,
  output logic [OFF_W-1:0]            bankAddr,
  output logic [WORD_W-1:0]           bankWdata,
  output logic [WORD_W-1:0]           rdData,
  output logic                        rdValid,
  output logic                        errOverrun,
  output logic                        errUnderrun,
  output logic                        errBadPage,
  output logic                        updStrobe
);

  localparam int READ_BIT = WORD_W - 1;
  localparam int PAGE_LSB = READ_BIT - PAGE_W;
  localparam int OFF_LSB  = PAGE_LSB - OFF_W;
  localparam logic [PAGE_W-1:0] BANK_LIMIT = PAGE_W'(NUM_BANKS);

  logic [PAGE_W-1:0] pageReg;
  logic [OFF_W-1:0]  offReg;
  logic [WORD_W-1:0] bankRows [NUM_BANKS];
  logic [WORD_W-1:0] selData;

  assign pageOk    = pageReg < BANK_LIMIT;
  assign bankAddr  = offReg;
  assign bankWdata = wordIn;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankWe[b]   = strb.doWrite && (pageReg == PAGE_W'(b));
    assign bankRe[b]   = strb.doRead  && (pageReg == PAGE_W'(b));
    assign bankRows[b] = bankRdata[b*WORD_W +: WORD_W];
  end

  always_comb begin
    selData = '1;
    for (int b = 0; b < NUM_BANKS; b++)
      if (pageReg == PAGE_W'(b)) selData = bankRows[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readFlag <= 1'b0;
      pageReg  <= '0;
      offReg   <= '0;
    end else if (strb.loadCmd) begin
      readFlag <= wordIn[READ_BIT];
      pageReg  <= wordIn[PAGE_LSB +: PAGE_W];
      offReg   <= wordIn[OFF_LSB +: OFF_W];
    end else if (strb.readGo) begin
      offReg   <= offReg + OFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData      <= '0;
      rdValid     <= 1'b0;
      updStrobe   <= 1'b0;
      errOverrun  <= 1'b0;
      errUnderrun <= 1'b0;
      errBadPage  <= 1'b0;
    end else begin
      rdValid   <= strb.readGo;
      updStrobe <= strb.doWrite || strb.doRead;
      if (strb.readGo)      rdData      <= selData;
      if (strb.setOverrun)  errOverrun  <= 1'b1;
      if (strb.setUnderrun) errUnderrun <= 1'b1;
      if (strb.setBadPage)  errBadPage  <= 1'b1;
    end
  end

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bankWe, bankRe}));

  a_r8_bad_page_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !pageOk |-> (bankWe == '0 && bankRe == '0));

  a_r5_offset_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.readGo |=> offReg == $past(offReg) + OFF_W'(1));

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errOverrun |=> errOverrun);
  a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errUnderrun |=> errUnderrun);
  a_r9_badpage_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errBadPage |=> errBadPage);

  a_r10_strobe_follows: assert property (@(posedge clk) disable iff (!rstN)
    (bankWe != '0 || bankRe != '0) |=> updStrobe);
  a_r10_strobe_only: assert property (@(posedge clk) disable iff (!rstN)
    (bankWe == '0 && bankRe == '0) |=> !updStrobe);

endmodule

// File: rtl/pserFrontEnd.sv
module pserFrontEnd
  import pserFePkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int PAGE_W    = 4,
  parameter int OFF_W     = 6,
  parameter int NUM_BANKS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wordValid,
  input  logic [WORD_W-1:0]           wordIn,
  input  logic                        readReq,
  output logic                        rdValid,
  output logic [WORD_W-1:0]           rdData,
  output logic [NUM_BANKS-1:0]        bankWe,
  output logic [NUM_BANKS-1:0]        bankRe,
  output logic [OFF_W-1:0]            bankAddr,
  output logic [WORD_W-1:0]           bankWdata,
  input  logic [NUM_BANKS*WORD_W-1:0] bankRdata,
  output logic                        errOverrun,
  output logic                        errUnderrun,
  output logic                        errBadPage,
  output logic                        updStrobe
);

  feStrobe_t strb;
  logic      readFlag;
  logic      pageOk;
  logic      expectData;

  pserFeCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wordValid  (wordValid),
    .readReq    (readReq),
    .readFlag   (readFlag),
    .pageOk     (pageOk),
    .strb       (strb),
    .expectData (expectData)
  );

  pserFeDatapath #(
    .WORD_W    (WORD_W),
    .PAGE_W    (PAGE_W),
    .OFF_W     (OFF_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wordIn      (wordIn),
    .bankRdata   (bankRdata),
    .readFlag    (readFlag),
    .pageOk      (pageOk),
    .bankWe      (bankWe),
    .bankRe      (bankRe),
    .bankAddr    (bankAddr),
    .bankWdata   (bankWdata),
    .rdData      (rdData),
    .rdValid     (rdValid),
    .errOverrun  (errOverrun),
    .errUnderrun (errUnderrun),
    .errBadPage  (errBadPage),
    .updStrobe   (updStrobe)
  );

endmodule

// File: tb/pserFrontEnd_tb.sv
module pserFrontEnd_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] wordIn = '0;
  logic        readReq = 1'b0;
  logic        rdValid;
  logic [15:0] rdData;
  logic [2:0]  bankWe, bankRe;
  logic [5:0]  bankAddr;
  logic [15:0] bankWdata;
  logic [47:0] bankRdata;
  logic        errOverrun, errUnderrun, errBadPage, updStrobe;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [15:0] expQ[$];
  string       reqQ[$];
  logic [3:0]  tbPage = '0;
  logic [5:0]  tbOff = '0;

  always #10 clk = ~clk;  // 50 MHz

  pserFrontEnd u_dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .readReq(readReq), .rdValid(rdValid), .rdData(rdData),
    .bankWe(bankWe), .bankRe(bankRe), .bankAddr(bankAddr),
    .bankWdata(bankWdata), .bankRdata(bankRdata),
    .errOverrun(errOverrun), .errUnderrun(errUnderrun),
    .errBadPage(errBadPage), .updStrobe(updStrobe)
  );

  // Simple bank model: three 64-entry register files.
  logic [15:0] mem [0:2][0:63];
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 64; j++)
          mem[i][j] <= {6'(i), 4'h0, 6'(j)} ^ 16'h3C00;
    end else begin
      for (int i = 0; i < 3; i++)
        if (bankWe[i]) mem[i][bankAddr] <= bankWdata;
    end
  end
  assign bankRdata = {mem[2][bankAddr], mem[1][bankAddr], mem[0][bankAddr]};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor for read results.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) chk("R11 unexpected read result", 32'(rdData), 32'hDEAD);
      else begin
        logic [15:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        chk(r, 32'(rdData), 32'(e));
      end
    end
  end

  function automatic logic [15:0] cmdWord(input logic rd, input logic [3:0] pg, input logic [5:0] off);
    return {rd, pg, off, 5'h15};  // low bits deliberately non-zero (R2)
  endfunction

  task automatic putWord(input logic [15:0] w, input logic [2:0] expWe, input string req);
    @(negedge clk);
    wordIn = w; wordValid = 1'b1;
    #1;
    chk(req, 32'(bankWe), 32'(expWe));
    if (expWe != 3'b000) begin
      chk(req, 32'(bankAddr), 32'(tbOff));
      chk(req, 32'(bankWdata), 32'(w));
    end
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic setCmd(input logic rd, input logic [3:0] pg, input logic [5:0] off);
    putWord(cmdWord(rd, pg, off), 3'b000, "R2 command word strobes nothing");
    tbPage = pg; tbOff = off;
  endtask

  task automatic writeReg(input logic [3:0] pg, input logic [5:0] off, input logic [15:0] d, input string req);
    logic [2:0] we;
    setCmd(1'b0, pg, off);
    we = (pg < 3) ? 3'(1 << pg) : 3'b000;
    putWord(d, we, req);
    chk({req, " R10 strobe after write"}, 32'(updStrobe), 32'(we != 3'b000));
  endtask

  task automatic readWord(input string req);
    @(negedge clk);
    readReq = 1'b1;
    expQ.push_back((tbPage < 3) ? mem[tbPage[1:0]][tbOff] : 16'hFFFF);
    reqQ.push_back(req);
    @(negedge clk);
    readReq = 1'b0;
    chk({req, " R10 strobe after read"}, 32'(updStrobe), 32'(tbPage < 3));
    tbOff = tbOff + 6'd1;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    tbPage = '0; tbOff = '0;
    @(negedge clk);
  endtask

  initial begin
    doReset();
    // R1 reset state
    chk("R1 errors", 32'({errOverrun, errUnderrun, errBadPage}), 32'h0);
    chk("R1 rdValid/updStrobe", 32'({rdValid, updStrobe}), 32'h0);
    chk("R1 strobes", 32'({bankWe, bankRe}), 32'h0);
    // R1: first word is a command -> no bank write
    writeReg(4'd1, 6'd5, 16'hA5A5, "R1 R3 R4 control write");
    writeReg(4'd0, 6'd63, 16'h1111, "R4 data-bank write");
    writeReg(4'd2, 6'd0, 16'h2222, "R4 audio-bank write");
    chk("R3 no errors after writes", 32'({errOverrun, errUnderrun, errBadPage}), 32'h0);
    @(negedge clk);
    chk("R10 strobe one cycle", 32'(updStrobe), 32'h0);

    // R5 sequential reads, R2 low bits ignored
    setCmd(1'b1, 4'd1, 6'd5);
    readWord("R5 R2 read control 5");
    readWord("R5 sequential read control 6");
    setCmd(1'b1, 4'd0, 6'd63);
    readWord("R5 read data 63");
    readWord("R5 offset wrap to 0");
    setCmd(1'b1, 4'd2, 6'd0);
    readWord("R5 read audio 0");
    chk("R7 no underrun on read command", 32'(errUnderrun), 32'h0);

    // R6 overrun
    setCmd(1'b1, 4'd0, 6'd3);
    putWord(16'h1234, 3'b000, "R6 overrun writes nothing");
    chk("R6 overrun flag", 32'(errOverrun), 32'h1);
    chk("R6 no strobe", 32'(updStrobe), 32'h0);
    writeReg(4'd0, 6'd3, 16'h5555, "R6 framing back to command");

    // R7 underrun: last command was a write
    readWord("R7 underrun read still served");
    chk("R7 underrun flag", 32'(errUnderrun), 32'h1);

    // R8 bad page
    writeReg(4'd5, 6'd2, 16'hBEEF, "R8 bad page write dropped");
    chk("R8 bad page flag", 32'(errBadPage), 32'h1);
    setCmd(1'b1, 4'd7, 6'd0);
    readWord("R8 bad page read all ones");

    // R9 sticky across good traffic
    writeReg(4'd1, 6'd9, 16'h0F0F, "R9 good write");
    setCmd(1'b1, 4'd1, 6'd9);
    readWord("R9 good readback");
    repeat (2) @(negedge clk);
    chk("R9 errors stay set", 32'({errOverrun, errUnderrun, errBadPage}), 32'h7);
    doReset();
    chk("R9 reset clears errors", 32'({errOverrun, errUnderrun, errBadPage}), 32'h0);

    // R11 word and read in the same cycle
    @(negedge clk);
    wordIn = cmdWord(1'b1, 4'd1, 6'd5); wordValid = 1'b1; readReq = 1'b1;
    @(negedge clk);
    wordValid = 1'b0; readReq = 1'b0;
    chk("R11 read dropped", 32'(rdValid), 32'h0);
    chk("R11 no underrun", 32'(errUnderrun), 32'h0);
    tbPage = 4'd1; tbOff = 6'd5;
    readWord("R11 command taken");
    repeat (3) @(negedge clk);
    chk("R5 all reads returned", 32'(expQ.size()), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule